// File: doc/BRIEF.md
# Bus Master Tenure Latency Timer

This block lives inside a master on a shared bus and decides when that master has to wind up its burst. Software programs a latency value, counted in bus clock cycles, through a simple write port. When the master starts a transaction after winning arbitration, the block loads that value into a down counter. The counter then counts down once per clock for as long as the transaction is active.

While cycles remain on the counter, the master keeps ownership even if the arbiter withdraws its grant. The value therefore buys a guaranteed minimum tenure, large enough to cover the fixed start-up cost of address/data multiplexing and the driver turnaround idle cycle. It is not a cap on tenure. Once the count has run out, a master that is still granted may keep bursting. Only when grant has also been removed, which means another master wants the bus, does the block ask the burst engine to finish the data phase in flight.

The burst engine signals the end of the transaction with a completion strobe. That may arrive several cycles after the request to release. The block then answers with a one-cycle release pulse and returns to idle.

Top module: `tenure_timer`

## Requirements
- R1: A synchronous active-high reset clears the latency register and the counter and leaves txn_active, timer_expired, must_release and bus_release low. A transaction started right after reset therefore sees timer_expired high in its first active cycle.
- R2: When txn_start is high while idle, the clock edge sets txn_active and loads the latency value L. timer_expired is low for the first L active cycles and goes high exactly L clock edges after the load edge.
- R3: Once timer_expired is high it stays high for as long as the transaction lasts. txn_active is never dropped because of elapsed time, so a master that stays granted keeps the bus indefinitely.
- R4: must_release is high exactly when txn_active and timer_expired are high and grant is low. While grant is high, must_release stays low.
- R5: When last_phase_done is high during an active transaction, the next edge clears txn_active and timer_expired. bus_release is high for exactly that one following cycle.
- R6: Assertion of must_release does not end the transaction by itself. txn_active stays high, for any number of cycles, until last_phase_done arrives.
- R7: A write to the latency register during a transaction does not change the count in progress. The written value is used on the next load.
- R8: A latency value of 0 makes timer_expired high in the first active cycle. must_release then follows the inverse of grant from that cycle on.
- R9: txn_start while a transaction is active is ignored. The count is not reloaded and the expiry time is unchanged.
- R10: last_phase_done while idle is ignored and produces no bus_release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the latency register |
| cfg_lat | input | CNT_W | Latency value to write, in bus clock cycles |
| txn_start | input | 1 | First address cycle of a new transaction after arbitration is won |
| grant | input | 1 | Bus grant from the arbiter; low means another master is waiting |
| last_phase_done | input | 1 | Burst engine has completed the final data phase |
| txn_active | output | 1 | A transaction owned by this master is in progress |
| timer_expired | output | 1 | Guaranteed tenure used up for the current transaction |
| must_release | output | 1 | Burst engine must finish the current phase and let go of the bus |
| bus_release | output | 1 | One-cycle pulse when the bus is handed back |

## Verification
A counter that is off by one, reloaded or not reloaded shows up at timer_expired as an expiry edge one or more cycles away from L edges after the load. The bench catches this within the transaction, for every latency value in its sweep. A stuck or leaking ownership state shows on txn_active and bus_release no later than the edge after last_phase_done. A latency register that is updated at the wrong time shows as a wrong expiry distance in the transaction that follows. Dropping grant in every phase checks that must_release never rises before expiry and rises in the same cycle as expiry.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  // Ownership phase of the master
  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_OWN  = 1'b1
  } tenure_state_e;
endpackage

// File: rtl/tenure_lat_reg.sv
module tenure_lat_reg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/tenure_down_counter.sv
module tenure_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt <= CNT_ZERO;
    else if (load)                  cnt <= load_val;
    else if (en && cnt != CNT_ZERO) cnt <= cnt - CNT_ONE;
  end

  assign zero = (cnt == CNT_ZERO);
endmodule

// File: rtl/tenure_own_ctl.sv
module tenure_own_ctl
  import tenure_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic txn_start,
  input  logic last_phase_done,
  output logic start_ok,
  output logic close_ok,
  output logic owning,
  output logic release_pulse
);
  tenure_state_e state;

  assign start_ok = (state == TS_IDLE) && txn_start;
  assign close_ok = (state == TS_OWN) && last_phase_done;
  assign owning   = (state == TS_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= TS_IDLE;
      release_pulse <= 1'b0;
    end else begin
      release_pulse <= close_ok;
      if (start_ok)      state <= TS_OWN;
      else if (close_ok) state <= TS_IDLE;
    end
  end
endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_lat,
  input  logic             txn_start,
  input  logic             grant,
  input  logic             last_phase_done,
  output logic             txn_active,
  output logic             timer_expired,
  output logic             must_release,
  output logic             bus_release
);
  logic [CNT_W-1:0] lat_q;
  logic             start_ok;
  logic             close_ok;
  logic             owning;
  logic             cnt_zero;

  tenure_lat_reg #(.CNT_W(CNT_W)) u_lat (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_lat),
    .q     (lat_q)
  );

  tenure_own_ctl u_ctl (
    .clk             (clk),
    .rst             (rst),
    .txn_start       (txn_start),
    .last_phase_done (last_phase_done),
    .start_ok        (start_ok),
    .close_ok        (close_ok),
    .owning          (owning),
    .release_pulse   (bus_release)
  );

  tenure_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (close_ok),
    .load     (start_ok),
    .load_val (lat_q),
    .en       (owning),
    .zero     (cnt_zero)
  );

  assign txn_active    = owning;
  assign timer_expired = owning && cnt_zero;
  assign must_release  = timer_expired && !grant;
endmodule

// File: rtl/tenure_timer_chk.sv
module tenure_timer_chk (
  input logic clk,
  input logic rst,
  input logic grant,
  input logic last_phase_done,
  input logic txn_active,
  input logic timer_expired,
  input logic must_release,
  input logic bus_release
);
  a_r4_grant_blocks: assert property (@(posedge clk) disable iff (rst)
    grant |-> !must_release);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !txn_active |-> (!must_release && !timer_expired));
  a_r3_expiry_sticky: assert property (@(posedge clk) disable iff (rst)
    (txn_active && timer_expired && !last_phase_done) |=> timer_expired);
  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    (txn_active && !last_phase_done) |=> txn_active);
  a_r5_close_pulse: assert property (@(posedge clk) disable iff (rst)
    (txn_active && last_phase_done) |=> (bus_release && !txn_active));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bus_release |=> !bus_release);
  a_r10_idle_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !txn_active |=> !bus_release);
endmodule

bind tenure_timer tenure_timer_chk i_chk (
  .clk             (clk),
  .rst             (rst),
  .grant           (grant),
  .last_phase_done (last_phase_done),
  .txn_active      (txn_active),
  .timer_expired   (timer_expired),
  .must_release    (must_release),
  .bus_release     (bus_release)
);

// File: tb/test_tenure_timer.sv
`timescale 1ns/1ps
module test_tenure_timer;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_lat = '0;
  logic txn_start = 1'b0;
  logic grant = 1'b1;
  logic last_phase_done = 1'b0;
  logic txn_active, timer_expired, must_release, bus_release;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tenure_timer #(.CNT_W(CNT_W)) i_tenure_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
    .txn_start(txn_start), .grant(grant), .last_phase_done(last_phase_done),
    .txn_active(txn_active), .timer_expired(timer_expired),
    .must_release(must_release), .bus_release(bus_release)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_lat(input int v);
    cfg_we = 1'b1; cfg_lat = CNT_W'(v);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start_txn();
    txn_start = 1'b1;
    step();
    txn_start = 1'b0;
  endtask

  task automatic close_txn(input string req);
    last_phase_done = 1'b1;
    step();
    last_phase_done = 1'b0;
    check({req, " active cleared"}, txn_active, 1'b0);
    check({req, " release pulse"}, bus_release, 1'b1);
    check({req, " expired cleared"}, timer_expired, 1'b0);
    step();
    check({req, " pulse one cycle"}, bus_release, 1'b0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    check("R1 active", txn_active, 1'b0);
    check("R1 expired", timer_expired, 1'b0);
    check("R1 must_release", must_release, 1'b0);
    check("R1 bus_release", bus_release, 1'b0);
    start_txn();
    check("R1 cleared register gives immediate expiry", timer_expired, 1'b1);
    close_txn("R5");

    // R2, R4, R8, R5: sweep of latency values
    for (int lat = 0; lat <= 20; lat++) begin
      write_lat(lat);
      grant = 1'b1;
      start_txn();
      check("R2 active after start", txn_active, 1'b1);
      for (int j = 0; j <= lat + 2; j++) begin
        check((lat == 0) ? "R8 expiry" : "R2 expiry", timer_expired, (j >= lat));
        check("R4 granted no release", must_release, 1'b0);
        grant = 1'b0; #1;
        check("R4 release follows expiry", must_release, (j >= lat));
        grant = 1'b1;
        step();
      end
      close_txn("R5");
    end

    // R3, R6: long tenure, granted, then grant lost without completion
    write_lat(4);
    start_txn();
    for (int j = 0; j < 300; j++) step();
    check("R3 still active when granted", txn_active, 1'b1);
    check("R3 expiry held", timer_expired, 1'b1);
    grant = 1'b0;
    for (int j = 0; j < 7; j++) begin
      step();
      check("R6 active until done", txn_active, 1'b1);
      check("R6 must_release held", must_release, 1'b1);
    end
    grant = 1'b1;
    close_txn("R5");

    // R7: write during transaction
    write_lat(6);
    start_txn();
    step(); step();
    cfg_we = 1'b1; cfg_lat = 8'd1;
    step();
    cfg_we = 1'b0;
    step();   // j = 4
    check("R7 count kept at j=4", timer_expired, 1'b0);
    step();   // j = 5
    check("R7 count kept at j=5", timer_expired, 1'b0);
    step();   // j = 6
    check("R7 original expiry", timer_expired, 1'b1);
    close_txn("R5");
    start_txn();
    check("R7 new value not yet expired", timer_expired, 1'b0);
    step();
    check("R7 new value used", timer_expired, 1'b1);
    close_txn("R5");

    // R9: restart while active ignored
    write_lat(6);
    start_txn();
    step(); step(); step();  // j = 3
    txn_start = 1'b1;
    step();                   // j = 4
    txn_start = 1'b0;
    step();                   // j = 5
    check("R9 no reload at j=5", timer_expired, 1'b0);
    step();                   // j = 6
    check("R9 original expiry kept", timer_expired, 1'b1);
    close_txn("R5");

    // R10: completion strobe while idle
    last_phase_done = 1'b1;
    step();
    last_phase_done = 1'b0;
    check("R10 no pulse when idle", bus_release, 1'b0);
    check("R10 still idle", txn_active, 1'b0);
    step();
    check("R10 no late pulse", bus_release, 1'b0);

    // Maximum latency value
    write_lat(255);
    start_txn();
    for (int j = 0; j < 254; j++) step();
    check("R2 max value before expiry", timer_expired, 1'b0);
    step();
    check("R2 max value expiry", timer_expired, 1'b1);
    close_txn("R5");

    // R1: reset mid-transaction
    write_lat(9);
    start_txn();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 reset clears active", txn_active, 1'b0);
    start_txn();
    check("R1 reset clears register", timer_expired, 1'b1);
    close_txn("R5");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule